// File: doc/BRIEF.md
# Low-Power Bus Encoder and Decoder Link

This block pairs a transmit-side encoder with a receive-side decoder. They are joined by a W-bit group of bus lines, one side-band flag line and a word-valid line. Its purpose is to lower the switching activity on the bus lines. A static mode input selects one of three codes:

- **Data mode** uses bus-invert coding. A word is complemented when doing so reduces the number of line flips, and the flag marks the inversion.
- **Address mode** uses increment elision. When a word equals the previous address plus one, the lines stay frozen and only the flag is raised.
- **Transition mode** uses transition signalling. Each 1 bit toggles its line and each 0 bit leaves its line alone.

Both sides keep a copy of the last bus state and the last word. The decoder can therefore invert whichever code the encoder chose and hand back the exact original word. The mode is set while the link is in reset and held afterwards. The encoder registers a word onto the lines one cycle after it is accepted. The decoder registers the rebuilt word one cycle after that.

Top module: `lpbus_link`

## Requirements
- R1: While reset is held and on the first cycle after it, the bus lines, the flag line, link_valid and rx_valid are all zero, and the stored previous bus state and previous word on both sides are zero.
- R2: Mode codes are 0 for data, 1 for address and 2 for transition; code 3 behaves as data. In data mode, let D be the number of bit positions where the word differs from the current bus lines. When D is greater than W/2, the lines take the complement of the word and the flag is 1. When D is W/2 or less, including exactly W/2, the lines take the word itself and the flag is 0.
- R3: In data mode, no more than W/2 bus lines toggle per accepted word, so no more than W/2+1 lines toggle once the flag line is counted.
- R4: In address mode, a word equal to the previous accepted word plus one leaves the bus lines unchanged and sets the flag to 1. Any other word is placed on the lines as-is with the flag at 0. The first word after reset is always sent in full, whatever its value.
- R5: The address increment wraps modulo 2^W, so all-ones followed by zero counts as sequential.
- R6: In transition mode, the new bus lines are the old lines XOR the word and the flag stays 0. The number of line toggles therefore equals the number of 1 bits in the word.
- R7: In every mode, rx_word equals the word accepted on tx_word, with rx_valid high. It appears one clock after it was driven onto the bus, which is two clocks after tx_valid was sampled.
- R8: A cycle with tx_valid low changes neither the bus lines, nor the flag, nor any stored state on either side. It produces link_valid low, and rx_valid low one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Static code select: 0 data, 1 address, 2 transition |
| tx_valid | input | 1 | Word on tx_word is accepted this cycle |
| tx_word | input | W | Word to transmit |
| bus_lines | output | W | Encoded bus lines |
| bus_flag | output | 1 | Side-band line: inversion or increment marker |
| link_valid | output | 1 | Bus lines carry a new word this cycle |
| rx_valid | output | 1 | rx_word holds a rebuilt word |
| rx_word | output | W | Word rebuilt by the decoder |

## Verification
The bench builds the link with W = 8, so the inversion threshold is 4 differing bits. With that width, the exact-half tie can be produced with a single nibble pattern. The address wrap from 8'hFF to 8'h00 and an idle gap inside an address run are short directed sequences. The first-word case, where the word is 8'h01 and the reset-time previous value is zero, is also within reach of a short sequence.

// File: rtl/lpbus_pkg.sv
// Shared types for the low-power bus link.
// Assumes: mode is static while the link runs.
package lpbus_pkg;
    typedef enum logic [1:0] {
        MODE_DATA  = 2'd0,
        MODE_ADDR  = 2'd1,
        MODE_TRANS = 2'd2,
        MODE_RSVD  = 2'd3
    } lpbus_mode_e;
endpackage

// File: rtl/lpbus_ones.sv
// Counts the set bits of a vector; purely combinational.
// Assumes: CW is wide enough to hold the value W.
module lpbus_ones #(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    // Ripple sum of the set bits.
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/lpbus_encoder.sv
// Transmit side: chooses a code per word and drives the bus lines and flag.
// Assumes: mode is held constant between resets; state moves only on valid.
module lpbus_encoder
    import lpbus_pkg::*;
#(
    parameter int W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  lpbus_mode_e mode,
    input  logic        in_valid,
    input  logic [W-1:0] in_word,
    output logic [W-1:0] bus_out,
    output logic        flag_out,
    output logic        valid_out
);
    localparam int HALF = W / 2;
    localparam int CW   = $clog2(W + 1);

    logic [W-1:0]  bus_q, bus_d, prev_q;
    logic          flag_q, flag_d, have_prev_q, vld_q;
    logic [CW-1:0] diff_cnt;
    logic          started_q;

    lpbus_ones #(.W(W), .CW(CW)) u_diff (
        .vec   (in_word ^ bus_q),
        .count (diff_cnt)
    );

    // Next bus state and flag for the selected code.
    always_comb begin
        bus_d  = bus_q;
        flag_d = 1'b0;
        case (mode)
            MODE_ADDR: begin
                if (have_prev_q && (in_word == prev_q + W'(1))) begin
                    bus_d  = bus_q;
                    flag_d = 1'b1;
                end else begin
                    bus_d  = in_word;
                    flag_d = 1'b0;
                end
            end
            MODE_TRANS: begin
                bus_d  = bus_q ^ in_word;
                flag_d = 1'b0;
            end
            default: begin
                if (int'(diff_cnt) > HALF) begin
                    bus_d  = ~in_word;
                    flag_d = 1'b1;
                end else begin
                    bus_d  = in_word;
                    flag_d = 1'b0;
                end
            end
        endcase
    end

    // Register the lines, flag and previous word on accepted words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q       <= '0;
            flag_q      <= 1'b0;
            prev_q      <= '0;
            have_prev_q <= 1'b0;
            vld_q       <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                bus_q       <= bus_d;
                flag_q      <= flag_d;
                prev_q      <= in_word;
                have_prev_q <= 1'b1;
            end
        end
    end

    // Marks that one cycle has passed since reset, for history-based checks.
    always_ff @(posedge clk) begin
        if (!rst_n) started_q <= 1'b0;
        else        started_q <= 1'b1;
    end

    assign bus_out   = bus_q;
    assign flag_out  = flag_q;
    assign valid_out = vld_q;

    // R3
    data_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && vld_q && (mode == MODE_DATA))
            |-> ($countones(bus_q ^ $past(bus_q)) <= HALF));

    // R4
    addr_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && vld_q && (mode == MODE_ADDR) && flag_q)
            |-> (bus_q == $past(bus_q)));

    // R6
    trans_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TRANS) |-> !flag_q);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && !in_valid) |=> ($stable(bus_q) && $stable(flag_q) && !vld_q));
endmodule

// File: rtl/lpbus_decoder.sv
// Receive side: mirrors the encoder's state and rebuilds the original word.
// Assumes: the same static mode as the encoder; one cycle of latency.
module lpbus_decoder
    import lpbus_pkg::*;
#(
    parameter int W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  lpbus_mode_e mode,
    input  logic        in_valid,
    input  logic [W-1:0] bus_in,
    input  logic        flag_in,
    output logic        out_valid,
    output logic [W-1:0] out_word
);
    logic [W-1:0] last_bus_q, prev_word_q, word_d, word_q;
    logic         vld_q;
    logic         started_q;

    // Inverse of the encoder's code for the current mode.
    always_comb begin
        case (mode)
            MODE_ADDR:  word_d = flag_in ? (prev_word_q + W'(1)) : bus_in;
            MODE_TRANS: word_d = bus_in ^ last_bus_q;
            default:    word_d = flag_in ? ~bus_in : bus_in;
        endcase
    end

    // Register the rebuilt word and the mirrored state on valid bus words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_bus_q  <= '0;
            prev_word_q <= '0;
            word_q      <= '0;
            vld_q       <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                word_q      <= word_d;
                prev_word_q <= word_d;
                last_bus_q  <= bus_in;
            end
        end
    end

    // Marks that one cycle has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) started_q <= 1'b0;
        else        started_q <= 1'b1;
    end

    assign out_valid = vld_q;
    assign out_word  = word_q;

    // R7
    rx_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8
    rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && !in_valid) |=> (!out_valid && $stable(out_word)));
endmodule

// File: rtl/lpbus_link.sv
// Top: encoder and decoder joined by the encoded bus, flag and valid lines.
// Assumes: mode changes only while rst_n is low.
module lpbus_link
    import lpbus_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode,
    input  logic         tx_valid,
    input  logic [W-1:0] tx_word,
    output logic [W-1:0] bus_lines,
    output logic         bus_flag,
    output logic         link_valid,
    output logic         rx_valid,
    output logic [W-1:0] rx_word
);
    lpbus_mode_e mode_e;
    assign mode_e = lpbus_mode_e'(mode);

    lpbus_encoder #(.W(W)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_e),
        .in_valid  (tx_valid),
        .in_word   (tx_word),
        .bus_out   (bus_lines),
        .flag_out  (bus_flag),
        .valid_out (link_valid)
    );

    lpbus_decoder #(.W(W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_e),
        .in_valid  (link_valid),
        .bus_in    (bus_lines),
        .flag_in   (bus_flag),
        .out_valid (rx_valid),
        .out_word  (rx_word)
    );
endmodule

// File: tb/tb_lpbus_link.sv
module tb_lpbus_link;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode = 2'd0;
    logic         tx_valid = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic [W-1:0] bus_lines, rx_word;
    logic         bus_flag, link_valid, rx_valid;

    int checks = 0;
    int fails  = 0;

    // Bench-side model of the expected line state, built from the requirements.
    logic [W-1:0] m_bus, m_prev;
    logic         m_flag, m_have;

    lpbus_link #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .tx_valid(tx_valid),
        .tx_word(tx_word), .bus_lines(bus_lines), .bus_flag(bus_flag),
        .link_valid(link_valid), .rx_valid(rx_valid), .rx_word(rx_word)
    );

    always #2 clk = ~clk;

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int ones(input logic [W-1:0] v);
        int n = 0;
        for (int i = 0; i < W; i++) n += int'(v[i]);
        return n;
    endfunction

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0; tx_valid = 1'b0; mode = m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_bus = '0; m_prev = '0; m_flag = 1'b0; m_have = 1'b0;
        @(posedge clk); #1;
        // R1: all outputs zero right after reset
        chk(bus_lines == '0, "R1", "bus after reset", {1'b0, bus_lines}, '0);
        chk(!bus_flag && !link_valid && !rx_valid, "R1", "flags after reset",
            {6'd0, bus_flag, link_valid, rx_valid}, '0);
    endtask

    // Send one word, check the encoded lines, then the rebuilt word.
    task automatic send(input logic [W-1:0] w);
        logic [W-1:0] b0, eb;
        logic         f0, ef;
        b0 = bus_lines; f0 = bus_flag;
        case (mode)
            2'd1: begin
                if (m_have && w == m_prev + W'(1)) begin eb = m_bus; ef = 1'b1; end
                else begin eb = w; ef = 1'b0; end
            end
            2'd2: begin eb = m_bus ^ w; ef = 1'b0; end
            default: begin
                if (ones(w ^ m_bus) > W/2) begin eb = ~w; ef = 1'b1; end
                else begin eb = w; ef = 1'b0; end
            end
        endcase
        m_bus = eb; m_flag = ef; m_prev = w; m_have = 1'b1;
        @(negedge clk);
        tx_valid = 1'b1; tx_word = w;
        @(posedge clk); #1;
        chk(bus_lines == eb && bus_flag == ef && link_valid, "R2/R4/R6",
            "encoded lines", {bus_flag, bus_lines}, {ef, eb});
        if (mode == 2'd0)
            // R3: toggles bounded by W/2 (+1 for flag)
            chk(ones(bus_lines ^ b0) <= W/2 &&
                ones(bus_lines ^ b0) + int'(bus_flag != f0) <= W/2 + 1,
                "R3", "data toggle bound", (W+1)'(ones(bus_lines ^ b0)), (W+1)'(W/2));
        if (mode == 2'd2)
            // R6: toggles equal number of ones
            chk(ones(bus_lines ^ b0) == ones(w), "R6", "transition toggles",
                (W+1)'(ones(bus_lines ^ b0)), (W+1)'(ones(w)));
        if (mode == 2'd1 && ef)
            // R4: sequential address freezes lines
            chk(bus_lines == b0, "R4", "frozen lines", {1'b0, bus_lines}, {1'b0, b0});
        @(negedge clk);
        tx_valid = 1'b0;
        @(posedge clk); #1;
        // R7: round trip after one more cycle
        chk(rx_valid && rx_word == w, "R7", "round trip", {rx_valid, rx_word}, {1'b1, w});
    endtask

    task automatic test_data;
        do_reset(2'd0);
        send(8'hFF);
        // R2: inversion when 8 differ
        chk(bus_lines == 8'h00 && bus_flag, "R2", "inverted FF", {bus_flag, bus_lines}, 9'h100);
        send(8'h0F);
        // R2: exactly half differ -> not inverted
        chk(bus_lines == 8'h0F && !bus_flag, "R2", "tie not inverted", {bus_flag, bus_lines}, 9'h00F);
        send(8'hF1);
        chk(bus_lines == 8'h0E && bus_flag, "R2", "inverted F1", {bus_flag, bus_lines}, 9'h10E);
        send(8'h3C); send(8'hA5); send(8'h5A); send(8'h00); send(8'h7F);
    endtask

    task automatic test_addr;
        do_reset(2'd1);
        send(8'h01);
        // R4: first word after reset sent in full
        chk(bus_lines == 8'h01 && !bus_flag, "R4", "first word full", {bus_flag, bus_lines}, 9'h001);
        send(8'h02); send(8'h03); send(8'h04);
        send(8'h40);
        chk(bus_lines == 8'h40 && !bus_flag, "R4", "jump sent full", {bus_flag, bus_lines}, 9'h040);
        send(8'h41);
        send(8'hFF);
        send(8'h00);
        // R5: wrap counts as sequential
        chk(bus_lines == 8'hFF && bus_flag, "R5", "wrap frozen", {bus_flag, bus_lines}, 9'h1FF);
        send(8'h01);
    endtask

    task automatic test_trans;
        do_reset(2'd2);
        send(8'h5A); send(8'h5A); send(8'h00); send(8'hFF); send(8'h81);
        chk(bus_lines == (8'h5A ^ 8'h5A ^ 8'h00 ^ 8'hFF ^ 8'h81) && !bus_flag, "R6",
            "accumulated lines", {bus_flag, bus_lines}, {1'b0, 8'h7E});
    endtask

    task automatic test_idle;
        logic [W-1:0] b0;
        do_reset(2'd1);
        send(8'h20);
        b0 = bus_lines;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            // R8: idle cycles change nothing
            chk(bus_lines == b0 && !link_valid && !rx_valid && rx_word == 8'h20, "R8",
                "idle hold", {rx_valid, bus_lines}, {1'b0, b0});
        end
        send(8'h21);
        chk(bus_flag, "R8", "state kept across idle", {8'd0, bus_flag}, 9'd1);
    endtask

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        test_data();
        test_addr();
        test_trans();
        test_idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule